// File: doc/BRIEF.md
# Mode-Banked Integer Register File

This block is a 64-bit integer register file with 32 register numbers. A separate bank of eight shadow registers sits beside the normal bank. While the privileged-mode input is high, a fixed and non-contiguous group of register numbers is steered to the shadow bank. Code running in that mode therefore gets private scratch registers without saving the normal ones first.

Both combinational read ports and the single write port go through the same number-to-slot translation. A value stored under one mode can only be seen through that mode's view of the register numbers. Register number 31 is a constant zero. The privileged flag is a plain input, and the block has no logic for entering or leaving the mode.

Top module: `shadow_regfile`

## Requirements
- R1: With `priv_i` high, register numbers 8, 9, 10, 11, 12, 13 and 14 address shadow slots 0 to 6, in that order, for both reads and writes.
- R2: With `priv_i` high, register number 25 addresses shadow slot 7 for both reads and writes.
- R3: With `priv_i` low every register number addresses the normal bank. With `priv_i` high, every number outside 8 to 14 and 25 also addresses the normal bank.
- R4: A write to a number in the shadowed group made in one mode leaves the value seen for that number in the other mode unchanged.
- R5: Every register keeps all 64 bits of the written data, and reads return them bit-exact.
- R6: Reads of register number 31 return zero on both ports in both modes, and writes to it are discarded.
- R7: The two read ports are combinational and independent. A write is taken on the rising clock edge when `wr_en` is high, and has no effect when `wr_en` is low. A read of the register being written returns the old value until that edge.
- R8: A synchronous active-high reset clears every register of both banks to zero, and a write presented during reset is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| priv_i | input | 1 | Privileged mode; selects the shadow view |
| rd_addr_a | input | 5 | Register number for read port A |
| rd_data_a | output | 64 | Read data for port A (combinational) |
| rd_addr_b | input | 5 | Register number for read port B |
| rd_data_b | output | 64 | Read data for port B (combinational) |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Register number to write |
| wr_data | input | 64 | Data to write |

## Verification
Read results are due in the same cycle as the address and mode that select them, with no register on the path. The bench therefore drives each read on the falling edge and compares it one nanosecond later, before the next rising edge. A write takes effect at the first rising edge that samples `wr_en` high. The bench presents each write on a falling edge and reads the result back from the next falling edge onward, and it also reads the target before that edge to confirm the old value is still returned. Expected data comes from a bench model of both banks, updated through the bench's own mapping of register numbers to slots.

// File: rtl/shadow_rf_pkg.sv
package shadow_rf_pkg;
  localparam int unsigned NUM_ARCH        = 32;
  localparam int unsigned NUM_SHADOW      = 8;
  localparam int unsigned AW              = $clog2(NUM_ARCH);
  localparam int unsigned SW              = $clog2(NUM_SHADOW);
  localparam int unsigned ZERO_REG        = NUM_ARCH - 1;
  localparam int unsigned SHADOW_RUN_BASE = 8;
  localparam int unsigned SHADOW_RUN_LEN  = 7;
  localparam int unsigned SHADOW_EXTRA    = 25;

  typedef struct packed {
    logic          to_shadow;
    logic          is_zero;
    logic [AW-1:0] idx;
  } slot_t;
endpackage

// File: rtl/rf_remap.sv
module rf_remap
  import shadow_rf_pkg::*;
(
  input  logic          priv_i,
  input  logic [AW-1:0] num_i,
  output slot_t         slot_o
);
  logic in_run;
  logic is_extra;

  always_comb begin
    in_run   = (32'(num_i) >= SHADOW_RUN_BASE) &&
               (32'(num_i) <  SHADOW_RUN_BASE + SHADOW_RUN_LEN);
    is_extra = (32'(num_i) == SHADOW_EXTRA);
    slot_o.is_zero   = (32'(num_i) == ZERO_REG);
    slot_o.to_shadow = priv_i && (in_run || is_extra);
    if (slot_o.to_shadow && in_run)
      slot_o.idx = AW'(32'(num_i) - SHADOW_RUN_BASE);
    else if (slot_o.to_shadow)
      slot_o.idx = AW'(SHADOW_RUN_LEN);
    else
      slot_o.idx = num_i;
  end
endmodule

// File: rtl/rf_bank.sv
module rf_bank #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned WIDTH = 64,
  parameter int unsigned NRD   = 2,
  localparam int unsigned IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic [IW-1:0]            waddr,
  input  logic [WIDTH-1:0]         wdata,
  input  logic [NRD-1:0][IW-1:0]   raddr,
  output logic [NRD-1:0][WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata[p] = mem[raddr[p]];
  end
endmodule

// File: rtl/shadow_regfile.sv
module shadow_regfile
  import shadow_rf_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              priv_i,
  input  logic [AW-1:0]     rd_addr_a,
  output logic [DATA_W-1:0] rd_data_a,
  input  logic [AW-1:0]     rd_addr_b,
  output logic [DATA_W-1:0] rd_data_b,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int unsigned NRD = 2;

  logic [NRD-1:0][AW-1:0]     rd_num;
  slot_t                      rd_slot [NRD];
  slot_t                      wr_slot;
  logic [NRD-1:0][AW-1:0]     norm_ra;
  logic [NRD-1:0][SW-1:0]     shad_ra;
  logic [NRD-1:0][DATA_W-1:0] norm_rd;
  logic [NRD-1:0][DATA_W-1:0] shad_rd;
  logic [NRD-1:0][DATA_W-1:0] port_rd;
  logic                       norm_we;
  logic                       shad_we;

  assign rd_num[0] = rd_addr_a;
  assign rd_num[1] = rd_addr_b;

  for (genvar p = 0; p < NRD; p++) begin : g_port
    rf_remap u_rd_map (
      .priv_i (priv_i),
      .num_i  (rd_num[p]),
      .slot_o (rd_slot[p])
    );
    assign norm_ra[p] = rd_slot[p].idx;
    assign shad_ra[p] = rd_slot[p].idx[SW-1:0];
    always_comb begin
      if (rd_slot[p].is_zero)        port_rd[p] = '0;
      else if (rd_slot[p].to_shadow) port_rd[p] = shad_rd[p];
      else                           port_rd[p] = norm_rd[p];
    end
  end

  rf_remap u_wr_map (
    .priv_i (priv_i),
    .num_i  (wr_addr),
    .slot_o (wr_slot)
  );

  assign norm_we = wr_en && !wr_slot.is_zero && !wr_slot.to_shadow;
  assign shad_we = wr_en && wr_slot.to_shadow;

  rf_bank #(.DEPTH(NUM_ARCH), .WIDTH(DATA_W), .NRD(NRD)) u_norm_bank (
    .clk   (clk),
    .rst   (rst),
    .we    (norm_we),
    .waddr (wr_slot.idx),
    .wdata (wr_data),
    .raddr (norm_ra),
    .rdata (norm_rd)
  );

  rf_bank #(.DEPTH(NUM_SHADOW), .WIDTH(DATA_W), .NRD(NRD)) u_shad_bank (
    .clk   (clk),
    .rst   (rst),
    .we    (shad_we),
    .waddr (wr_slot.idx[SW-1:0]),
    .wdata (wr_data),
    .raddr (shad_ra),
    .rdata (shad_rd)
  );

  assign rd_data_a = port_rd[0];
  assign rd_data_b = port_rd[1];

  AST_ZERO_READ_A: assert property (@(posedge clk) disable iff (rst)
    (32'(rd_addr_a) == ZERO_REG) |-> (rd_data_a == '0)); // R6
  AST_ZERO_READ_B: assert property (@(posedge clk) disable iff (rst)
    (32'(rd_addr_b) == ZERO_REG) |-> (rd_data_b == '0)); // R6
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (rd_data_a == '0 && rd_data_b == '0)); // R8
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && 32'(wr_addr) != ZERO_REG) |=>
      (rd_addr_a != $past(wr_addr) || priv_i != $past(priv_i) ||
       rd_data_a == $past(wr_data))); // R7
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
    (priv_i && $past(priv_i) && $stable(rd_addr_a) &&
     (rd_addr_a inside {[5'd8:5'd14], 5'd25}) && !$past(wr_en && priv_i))
      |-> $stable(rd_data_a)); // R4
endmodule

// File: tb/test_shadow_regfile.sv
module test_shadow_regfile;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        priv_i = 1'b0;
  logic [4:0]  rd_addr_a = '0, rd_addr_b = '0, wr_addr = '0;
  logic [63:0] rd_data_a, rd_data_b, wr_data = '0;
  logic        wr_en = 1'b0;

  int unsigned errors = 0, checks = 0;
  logic [63:0] norm_m [32];
  logic [63:0] shad_m [8];
  bit          done = 0;

  always #4 clk = ~clk;

  shadow_regfile i_shadow_regfile (
    .clk(clk), .rst(rst), .priv_i(priv_i),
    .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
    .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  function automatic int shad_slot(bit p, int n);
    if (!p) return -1;
    if (n >= 8 && n <= 14) return n - 8;
    if (n == 25) return 7;
    return -1;
  endfunction

  function automatic logic [63:0] model(bit p, int n);
    int s = shad_slot(p, n);
    if (n == 31) return '0;
    if (s >= 0) return shad_m[s];
    return norm_m[n];
  endfunction

  function automatic string tag(bit p, int n);
    if (n == 31) return "R6";
    if (shad_slot(p, n) == 7) return "R2";
    if (shad_slot(p, n) >= 0) return "R1";
    return "R3";
  endfunction

  function automatic logic [63:0] pat(bit p, int n);
    return (64'(n + 1) * 64'h0101_0101_0101_0101) ^ (p ? 64'hF00D_0000_0000_BEEF : 64'h8000_0000_0000_0001);
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(bit p, int n, logic [63:0] d);
    int s = shad_slot(p, n);
    @(negedge clk);
    priv_i = p; wr_en = 1'b1; wr_addr = 5'(n); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (n != 31) begin
      if (s >= 0) shad_m[s] = d;
      else norm_m[n] = d;
    end
  endtask

  task automatic read_both(bit p, int a, int b, string extra);
    @(negedge clk);
    priv_i = p; rd_addr_a = 5'(a); rd_addr_b = 5'(b);
    #1;
    check({tag(p, a), extra}, rd_data_a, model(p, a));
    check({tag(p, b), extra}, rd_data_b, model(p, b));
  endtask

  task automatic sweep(string extra);
    for (int m = 0; m < 2; m++)
      for (int n = 0; n < 32; n++)
        read_both(bit'(m), n, 31 - n, extra);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    wr_en = 1'b1; wr_addr = 5'd3; wr_data = 64'hDEAD_BEEF_0000_1111;
    repeat (3) @(negedge clk);
    rst = 1'b0; wr_en = 1'b0;
    for (int i = 0; i < 32; i++) norm_m[i] = '0;
    for (int i = 0; i < 8; i++) shad_m[i] = '0;
  endtask

  initial begin
    do_reset();
    sweep(" R8 reset");
    // fill both views, normal first, then privileged
    for (int n = 0; n < 32; n++) do_write(1'b0, n, pat(1'b0, n));
    for (int n = 0; n < 32; n++) do_write(1'b1, n, pat(1'b1, n));
    sweep(" R4 R5 fill");
    // R4: privileged write to r12 leaves normal r12 intact
    do_write(1'b1, 12, 64'h1234_5678_9ABC_DEF0);
    read_both(1'b0, 12, 25, " R4 cross-mode");
    read_both(1'b1, 12, 25, " R4 own-mode");
    // R5: all-ones and alternating patterns
    do_write(1'b0, 5, '1);
    do_write(1'b1, 25, 64'hAAAA_AAAA_5555_5555);
    read_both(1'b0, 5, 25, " R5 width");
    read_both(1'b1, 5, 25, " R5 width");
    // R6: writes to r31 in both modes
    do_write(1'b0, 31, '1);
    do_write(1'b1, 31, '1);
    read_both(1'b0, 31, 31, " R6 zero");
    read_both(1'b1, 31, 31, " R6 zero");
    // R7: old value before the edge, new after; no write with enable low
    @(negedge clk);
    priv_i = 1'b1; rd_addr_a = 5'd9; rd_addr_b = 5'd9;
    wr_en = 1'b1; wr_addr = 5'd9; wr_data = 64'h0BAD_F00D_CAFE_0001;
    #1;
    check("R7 old value", rd_data_a, shad_m[1]);
    @(negedge clk);
    wr_en = 1'b0; shad_m[1] = 64'h0BAD_F00D_CAFE_0001;
    #1;
    check("R7 new value", rd_data_b, shad_m[1]);
    @(negedge clk);
    priv_i = 1'b0; wr_en = 1'b0; wr_addr = 5'd7; wr_data = 64'h7777_0000_7777_0000;
    rd_addr_a = 5'd7;
    @(negedge clk);
    #1;
    check("R7 enable low", rd_data_a, norm_m[7]);
    sweep(" R7 final");
    do_reset();
    sweep(" R8 second reset");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule